// File: doc/BRIEF.md
# Communication Cycle Controller

This block paces a time-triggered bus node through its repeating communication cycle. Each clock is one macrotick. When enabled, it waits a programmable startup delay, then pulses a cycle-start strobe to the static-slot sequencer and sets the cycle number to 1. It then follows the cycle through its phases. The static phase lasts until the static sequencer reports done, and the dynamic phase lasts until the dynamic sequencer reports done. An optional symbol window follows. A network idle time then runs out whatever macroticks are left of the fixed cycle length and resets the slot counters.

At each cycle boundary the cycle number steps up, or goes back to 1 after the configured maximum. A stop request, meaning the enable is dropped or halt is raised, takes effect only at a cycle boundary. The controller then returns to idle and clears the cycle number. A combinational configuration check refuses to start when the cycle length cannot hold the static, dynamic and symbol phases plus at least one idle macrotick, or when the maximum cycle number is zero.

Top module: `cycle_sequencer`

## Requirements
- R1: After reset the phase is idle (code 0), the cycle number and macrotick index are 0, and neither strobe is high.
- R2: From idle, with run high, halt low and no configuration error, the controller spends one clock in idle and `cfg_offset_i`+1 clocks in the offset phase (code 1). It then pulses `cycle_start_o` for one clock, together with phase static (code 2), cycle number 1 and macrotick index 0.
- R3: At a cycle boundary with run high and halt low, a cycle number below the maximum increments and a new cycle starts at once.
- R4: At a cycle boundary where the cycle number equals the maximum, the next cycle is numbered 1.
- R5: Phases run in a fixed order: static (2) until `static_done_i` is sampled high, then dynamic (3) until `dyn_done_i` is sampled high, then symbol (4), then network idle (5).
- R6: The symbol phase lasts exactly `cfg_sym_len_i` clocks. A length of 0 skips it, so dynamic goes straight to network idle.
- R7: `slot_rst_o` pulses for one clock on entry to network idle. Network idle ends at macrotick index `cfg_cyc_len_i`-1, so cycle starts are exactly `cfg_cyc_len_i` clocks apart.
- R8: Run and halt act only in idle and at a cycle boundary. A stop at a boundary returns the controller to idle with cycle number 0.
- R9: `cfg_err_o` is high when `cfg_cyc_len_i` < static+dynamic+symbol lengths+1, or when `cfg_max_cyc_i` is 0. While it is high the controller does not leave idle.
- R10: The macrotick index is 0 in the first clock of a cycle and rises by one per clock until the cycle boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one macrotick per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Node is in normal active operation |
| halt_i | input | 1 | Stop at the next cycle boundary |
| cfg_max_cyc_i | input | CNT_W | Highest cycle number before wrapping to 1 |
| cfg_offset_i | input | MT_W | Startup delay before the first cycle |
| cfg_cyc_len_i | input | MT_W | Total cycle length in macroticks |
| cfg_static_len_i | input | MT_W | Static phase length, used only by the check |
| cfg_dyn_len_i | input | MT_W | Dynamic phase length, used only by the check |
| cfg_sym_len_i | input | MT_W | Symbol window length, 0 to skip |
| static_done_i | input | 1 | Static sequencer finished |
| dyn_done_i | input | 1 | Dynamic sequencer finished |
| cycle_start_o | output | 1 | One-clock cycle-start strobe |
| cycle_cnt_o | output | CNT_W | Current cycle number, 0 when stopped |
| phase_o | output | 3 | Phase code: 0 idle, 1 offset, 2 static, 3 dynamic, 4 symbol, 5 idle time |
| mt_o | output | MT_W | Macrotick index within the cycle |
| slot_rst_o | output | 1 | Slot counter reset strobe |
| cfg_err_o | output | 1 | Configuration inconsistent |

## Verification
A wrong phase register shows at `phase_o` in the same clock and moves the next cycle-start strobe within one cycle length. A wrong timer shows up within one cycle as a symbol window or cycle of the wrong length. A cycle-number fault is visible at the next start strobe, and at the latest at the wrap after the maximum cycle. Because a reference model is compared on every clock, any divergence is reported in the first clock it reaches a port.

// File: rtl/cycle_sequencer_pkg.sv
package cycle_sequencer_pkg;
   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_OFFS = 3'd1,
      PH_STAT = 3'd2,
      PH_DYN  = 3'd3,
      PH_SYM  = 3'd4,
      PH_NIT  = 3'd5
   } cyc_phase_t;
endpackage

// File: rtl/cycle_cfg_check.sv
module cycle_cfg_check #(
   parameter int CNT_W = 6,
   parameter int MT_W  = 12
) (
   input  logic [CNT_W-1:0] max_cyc_i,
   input  logic [MT_W-1:0]  cyc_len_i,
   input  logic [MT_W-1:0]  static_len_i,
   input  logic [MT_W-1:0]  dyn_len_i,
   input  logic [MT_W-1:0]  sym_len_i,
   output logic             err_o
);
   localparam int SUM_W = MT_W + 2;

   logic [SUM_W-1:0] need;

   always_comb begin
      need = SUM_W'(static_len_i) + SUM_W'(dyn_len_i) + SUM_W'(sym_len_i) + SUM_W'(1);
      err_o = (max_cyc_i == '0) || (SUM_W'(cyc_len_i) < need);
   end
endmodule

// File: rtl/cycle_num_counter.sv
module cycle_num_counter #(
   parameter int CNT_W = 6
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             first_i,
   input  logic             adv_i,
   input  logic             clr_i,
   input  logic [CNT_W-1:0] max_i,
   output logic [CNT_W-1:0] cnt_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (first_i) begin
         cnt_q <= CNT_W'(1);
      end else if (adv_i) begin
         cnt_q <= (cnt_q >= max_i) ? CNT_W'(1) : cnt_q + CNT_W'(1);
      end else if (clr_i) begin
         cnt_q <= '0;
      end
   end

   assign cnt_o = cnt_q;

   AST_WRAP_TO_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (adv_i && cnt_q == max_i) |=> cnt_q == CNT_W'(1)); // R4
endmodule

// File: rtl/cycle_phase_fsm.sv
module cycle_phase_fsm
   import cycle_sequencer_pkg::*;
#(
   parameter int MT_W = 12
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            go_i,
   input  logic [MT_W-1:0] offset_i,
   input  logic [MT_W-1:0] cyc_len_i,
   input  logic [MT_W-1:0] sym_len_i,
   input  logic            static_done_i,
   input  logic            dyn_done_i,
   output cyc_phase_t      phase_o,
   output logic [MT_W-1:0] mt_o,
   output logic            start_o,
   output logic            slot_rst_o,
   output logic            first_o,
   output logic            adv_o,
   output logic            stop_o
);
   cyc_phase_t      phase_q;
   logic [MT_W-1:0] mt_q;
   logic [MT_W-1:0] tmr_q;
   logic            start_q;
   logic            srst_q;
   logic            boundary;

   always_comb begin
      boundary = (phase_q == PH_NIT) &&
                 (({1'b0, mt_q} + {{MT_W{1'b0}}, 1'b1}) >= {1'b0, cyc_len_i});
      first_o  = (phase_q == PH_OFFS) && (tmr_q == '0);
      adv_o    = boundary && go_i;
      stop_o   = boundary && !go_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q <= PH_IDLE;
         mt_q    <= '0;
         tmr_q   <= '0;
         start_q <= 1'b0;
         srst_q  <= 1'b0;
      end else begin
         start_q <= first_o || adv_o;
         srst_q  <= 1'b0;
         case (phase_q)
            PH_IDLE: begin
               if (go_i) begin
                  phase_q <= PH_OFFS;
                  tmr_q   <= offset_i;
               end
            end
            PH_OFFS: begin
               if (tmr_q == '0) begin
                  phase_q <= PH_STAT;
                  mt_q    <= '0;
               end else begin
                  tmr_q <= tmr_q - MT_W'(1);
               end
            end
            PH_STAT: begin
               mt_q <= mt_q + MT_W'(1);
               if (static_done_i) phase_q <= PH_DYN;
            end
            PH_DYN: begin
               mt_q <= mt_q + MT_W'(1);
               if (dyn_done_i) begin
                  if (sym_len_i == '0) begin
                     phase_q <= PH_NIT;
                     srst_q  <= 1'b1;
                  end else begin
                     phase_q <= PH_SYM;
                     tmr_q   <= sym_len_i - MT_W'(1);
                  end
               end
            end
            PH_SYM: begin
               mt_q <= mt_q + MT_W'(1);
               if (tmr_q == '0) begin
                  phase_q <= PH_NIT;
                  srst_q  <= 1'b1;
               end else begin
                  tmr_q <= tmr_q - MT_W'(1);
               end
            end
            PH_NIT: begin
               if (boundary) begin
                  mt_q    <= '0;
                  phase_q <= go_i ? PH_STAT : PH_IDLE;
               end else begin
                  mt_q <= mt_q + MT_W'(1);
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign phase_o    = phase_q;
   assign mt_o       = mt_q;
   assign start_o    = start_q;
   assign slot_rst_o = srst_q;

   AST_SYM_WITHIN_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_q == PH_SYM) |-> (tmr_q < sym_len_i)); // R6
endmodule

// File: rtl/cycle_sequencer.sv
module cycle_sequencer
   import cycle_sequencer_pkg::*;
#(
   parameter int CNT_W  = 6,
   parameter int MT_W   = 12,
   parameter bit SYM_EN = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic             halt_i,
   input  logic [CNT_W-1:0] cfg_max_cyc_i,
   input  logic [MT_W-1:0]  cfg_offset_i,
   input  logic [MT_W-1:0]  cfg_cyc_len_i,
   input  logic [MT_W-1:0]  cfg_static_len_i,
   input  logic [MT_W-1:0]  cfg_dyn_len_i,
   input  logic [MT_W-1:0]  cfg_sym_len_i,
   input  logic             static_done_i,
   input  logic             dyn_done_i,
   output logic             cycle_start_o,
   output logic [CNT_W-1:0] cycle_cnt_o,
   output logic [2:0]       phase_o,
   output logic [MT_W-1:0]  mt_o,
   output logic             slot_rst_o,
   output logic             cfg_err_o
);
   if (CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W must be at least 2");
   end
   if (MT_W < 4) begin : g_bad_mt
      $error("MT_W must be at least 4");
   end

   logic [MT_W-1:0] sym_len_eff;

   if (SYM_EN) begin : g_sym
      assign sym_len_eff = cfg_sym_len_i;
   end else begin : g_nosym
      assign sym_len_eff = '0;
   end

   cyc_phase_t phase_w;
   logic       err_w;
   logic       go_w;
   logic       first_w;
   logic       adv_w;
   logic       stop_w;

   assign go_w = run_i && !halt_i && !err_w;

   cycle_cfg_check #(.CNT_W(CNT_W), .MT_W(MT_W)) u_check (
      .max_cyc_i   (cfg_max_cyc_i),
      .cyc_len_i   (cfg_cyc_len_i),
      .static_len_i(cfg_static_len_i),
      .dyn_len_i   (cfg_dyn_len_i),
      .sym_len_i   (sym_len_eff),
      .err_o       (err_w)
   );

   cycle_phase_fsm #(.MT_W(MT_W)) u_fsm (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .go_i         (go_w),
      .offset_i     (cfg_offset_i),
      .cyc_len_i    (cfg_cyc_len_i),
      .sym_len_i    (sym_len_eff),
      .static_done_i(static_done_i),
      .dyn_done_i   (dyn_done_i),
      .phase_o      (phase_w),
      .mt_o         (mt_o),
      .start_o      (cycle_start_o),
      .slot_rst_o   (slot_rst_o),
      .first_o      (first_w),
      .adv_o        (adv_w),
      .stop_o       (stop_w)
   );

   cycle_num_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .first_i(first_w),
      .adv_i  (adv_w),
      .clr_i  (stop_w),
      .max_i  (cfg_max_cyc_i),
      .cnt_o  (cycle_cnt_o)
   );

   assign phase_o   = phase_w;
   assign cfg_err_o = err_w;

   AST_START_HAS_NUMBER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cycle_start_o |-> (cycle_cnt_o != '0)); // R2
   AST_SLOT_RST_IN_NIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      slot_rst_o |-> (phase_w == PH_NIT)); // R7
   AST_START_THEN_SEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cycle_start_o |=> (phase_w == PH_STAT || phase_w == PH_DYN)); // R5
   AST_IDLE_NO_NUMBER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_w == PH_IDLE) |-> (cycle_cnt_o == '0)); // R8
endmodule

// File: tb/cycle_sequencer_test.sv
module cycle_sequencer_test;
   localparam int CNT_W = 6;
   localparam int MT_W  = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic             run = 1'b0, halt = 1'b0;
   logic [CNT_W-1:0] maxc = 6'd3;
   logic [MT_W-1:0]  offs = '0, cyc = 12'd10, stl = 12'd6, dyl = 12'd5, syl = 12'd3;
   logic             sd = 1'b0, dd = 1'b0;
   int               late = 0;

   logic             start_o, srst_o, err_o;
   logic [CNT_W-1:0] cnt_o;
   logic [2:0]       ph_o;
   logic [MT_W-1:0]  mt_o;

   cycle_sequencer #(.CNT_W(CNT_W), .MT_W(MT_W), .SYM_EN(1'b1)) uut (
      .clk_i(clk), .rst_ni(rst_n), .run_i(run), .halt_i(halt),
      .cfg_max_cyc_i(maxc), .cfg_offset_i(offs), .cfg_cyc_len_i(cyc),
      .cfg_static_len_i(stl), .cfg_dyn_len_i(dyl), .cfg_sym_len_i(syl),
      .static_done_i(sd), .dyn_done_i(dd),
      .cycle_start_o(start_o), .cycle_cnt_o(cnt_o), .phase_o(ph_o),
      .mt_o(mt_o), .slot_rst_o(srst_o), .cfg_err_o(err_o)
   );

   int checks = 0, errors = 0, clocks = 0;

   // reference model state
   int m_ph = 0, m_mt = 0, m_tmr = 0, m_cnt = 0;
   int m_start = 0, m_srst = 0;

   function automatic int m_err();
      return ((int'(cyc) < int'(stl) + int'(dyl) + int'(syl) + 1) || maxc == 0) ? 1 : 0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_mt = 0; m_tmr = 0; m_cnt = 0; m_start = 0; m_srst = 0;
      end else begin
         automatic int go = (run && !halt && m_err() == 0) ? 1 : 0;
         m_start = 0;
         m_srst  = 0;
         case (m_ph)
            0: if (go != 0) begin m_ph = 1; m_tmr = int'(offs); end
            1: if (m_tmr == 0) begin m_ph = 2; m_mt = 0; m_cnt = 1; m_start = 1; end
               else m_tmr--;
            2: begin m_mt++; if (sd) m_ph = 3; end
            3: begin
               m_mt++;
               if (dd) begin
                  if (syl == 0) begin m_ph = 5; m_srst = 1; end
                  else begin m_ph = 4; m_tmr = int'(syl) - 1; end
               end
            end
            4: begin
               m_mt++;
               if (m_tmr == 0) begin m_ph = 5; m_srst = 1; end else m_tmr--;
            end
            default: begin
               if (m_mt + 1 >= int'(cyc)) begin
                  m_mt = 0;
                  if (go != 0) begin
                     m_ph = 2; m_start = 1;
                     m_cnt = (m_cnt >= int'(maxc)) ? 1 : m_cnt + 1;
                  end else begin
                     m_ph = 0; m_cnt = 0;
                  end
               end else m_mt++;
            end
         endcase
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at clock %0d", tag, act, exp, clocks);
      end
   endtask

   // per-clock comparison and segment responder
   always @(negedge clk) begin
      clocks++;
      if (rst_n) begin
         chk("R5 phase", int'(ph_o), m_ph);
         chk("R3 cycle number", int'(cnt_o), m_cnt);
         chk("R10 macrotick", int'(mt_o), m_mt);
         chk("R2 start strobe", int'(start_o), m_start);
         chk("R7 slot reset", int'(srst_o), m_srst);
         chk("R9 config error", int'(err_o), m_err());
      end
      sd <= (m_ph == 2 && m_mt >= int'(stl) - 1);
      dd <= (m_ph == 3 && m_mt >= int'(stl) + int'(dyl) - 1 + late);
      if (clocks > 5000) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected below 5000 clocks", clocks);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic wait_start();
      for (int i = 0; i < 200 && !start_o; i++) @(negedge clk);
   endtask

   task automatic measure(output int len, output int nsym);
      len = 0; nsym = 0;
      do begin
         @(negedge clk);
         len++;
         if (ph_o == 3'd4) nsym++;
      end while (!start_o && len < 200);
   endtask

   initial begin
      int len, nsym;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset phase", int'(ph_o), 0);
      chk("R1 reset number", int'(cnt_o), 0);
      chk("R1 reset strobes", int'(start_o) + int'(srst_o), 0);

      // inconsistent configuration: 10 < 6+5+3+1
      run = 1'b1;
      repeat (8) @(negedge clk);
      chk("R9 stays idle on bad config", int'(ph_o), 0);
      chk("R9 error flag", int'(err_o), 1);

      run = 1'b0;
      @(negedge clk);
      cyc = 12'd20; offs = 12'd2; maxc = 6'd3;
      run = 1'b1;
      wait_start();
      chk("R2 first number", int'(cnt_o), 1);
      chk("R2 first macrotick", int'(mt_o), 0);
      for (int k = 0; k < 4; k++) begin
         measure(len, nsym);
         chk("R7 cycle length", len, 20);
         chk("R6 symbol clocks", nsym, 3);
         chk("R4 number after boundary", int'(cnt_o), ((k + 1) % 3) + 1);
      end

      repeat (5) @(negedge clk);
      halt = 1'b1;
      for (int i = 0; i < 60 && ph_o != 3'd0; i++) @(negedge clk);
      chk("R8 idle after halt", int'(ph_o), 0);
      chk("R8 number cleared", int'(cnt_o), 0);

      halt = 1'b0; syl = '0; offs = '0; maxc = 6'd2; late = 4;
      wait_start();
      chk("R2 restart number", int'(cnt_o), 1);
      for (int k = 0; k < 3; k++) begin
         measure(len, nsym);
         chk("R7 cycle length late done", len, 20);
         chk("R6 zero symbol skipped", nsym, 0);
         chk("R3 number", int'(cnt_o), (k % 2 == 0) ? 2 : 1);
      end

      run = 1'b0;
      for (int i = 0; i < 60 && ph_o != 3'd0; i++) @(negedge clk);
      chk("R8 idle after run drop", int'(ph_o), 0);
      @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule